// File: doc/BRIEF.md
# Configurable SPI Slave Interface

This block is the receiving end of a four-wire serial link, clocked entirely by the local system clock. The serial clock, select and data lines from an external master pass through two-flop synchronizers. Edges of the serial clock are detected in the system clock domain. Each character is shifted most significant bit first in both directions at once. The master's bit replaces a bit of the local shift register while the register's top bit is driven back to the master.

The host programs four things before a transfer:
- the select polarity,
- the clock idle level,
- the clock phase,
- the character length, 8 or 16 bits.

The host may load a transmit character while no bit of the current character has been shifted. When a full character has arrived, it is copied into a single read buffer and a sticky completion flag is raised. The flag can raise an interrupt. The data output comes as a value and enable pair, so the line is released whenever the block is not selected. A select that ends mid-character discards the partial character without any trace.

Top module: `spi_target_port`

## Requirements
- R1: `cfg_sel_pol` = 0 makes `sel_in` active low; `cfg_sel_pol` = 1 makes it active high. Only the active level lets a transfer proceed.
- R2: All three serial inputs are synchronized with two flops. A master clocking at one quarter of the system clock still delivers every received bit correctly.
- R3: Reception and transmission are full duplex and MSB first. `rx_data` equals the bits presented on `mosi_in`, taken in arrival order.
- R4: `cfg_cpol` gives the clock idle level, and a leading edge is a move away from that level. With `cfg_cpha` = 0, the first bit appears on `miso_out` at the select edge, later bits appear after trailing edges, and input is sampled on leading edges. With `cfg_cpha` = 1, output changes on leading edges and input is sampled on trailing edges.
- R5: `cfg_wide` = 0 selects 8-bit characters; bits 7:0 of the shift register are used, and `rx_data[15:8]` reads 0. `cfg_wide` = 1 selects 16-bit characters.
- R6: After the last bit of a character is sampled, `rx_data` takes the character and `done_flag` rises. `rx_data` changes at no other time. `done_flag` stays set until a one-cycle `done_clr` pulse; a clear and a set in the same cycle leave it set.
- R7: `irq` is high exactly when `done_flag` and `cfg_irq_en` are both high.
- R8: While the block is not selected, serial clock edges have no effect. Nothing is sampled or shifted, and `miso_oe` is 0.
- R9: If select goes inactive before a full character, the transfer is aborted. `rx_data` is unchanged, `done_flag` is not set, and the bit counter returns to 0, so the next transfer starts from bit 0.
- R10: A `tx_wr` pulse loads `tx_data` into the shift register when no bit of the current character has been sampled yet. Without such a load, the next transfer sends whatever the register holds, which is the last character received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sel_pol | input | 1 | Select active level (0 low, 1 high) |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | Clock phase |
| cfg_wide | input | 1 | Character length (0: 8 bits, 1: 16 bits) |
| cfg_irq_en | input | 1 | Interrupt enable |
| tx_wr | input | 1 | Transmit load strobe |
| tx_data | input | 16 | Transmit character |
| rx_data | output | 16 | Read buffer |
| done_flag | output | 1 | Sticky transfer-complete flag |
| done_clr | input | 1 | Flag clear pulse |
| irq | output | 1 | Interrupt request |
| sclk_in | input | 1 | Serial clock from master |
| sel_in | input | 1 | Slave select from master |
| mosi_in | input | 1 | Serial data from master |
| miso_out | output | 1 | Serial data to master |
| miso_oe | output | 1 | Output enable for `miso_out` |

## Verification
A wrong bit counter shows up on the ports within one character:
- the flag rises early or late, or
- `rx_data` holds a character shifted by some bits, which the following transfer exposes.

A wrong output bit shows up at once, at the master's next sample point. The bench compares every returned bit across all four clock modes. Abort and ignored-clock faults stay invisible until the next full transfer. For that reason, every such scenario is followed by a clean transfer whose received character and flag are checked.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;
  typedef struct packed {
    logic sel_pol;
    logic cpol;
    logic cpha;
    logic wide;
  } spi_cfg_t;
endpackage

// File: rtl/spi_tgt_sync.sv
module spi_tgt_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= (s == 0) ? d : stg[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_tgt_engine.sv
module spi_tgt_engine
  import spi_tgt_pkg::*;
#(
  parameter int DW = 16,
  localparam int CW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  spi_cfg_t      cfg,
  input  logic          sclk_s,
  input  logic          sel_s,
  input  logic          mosi_s,
  input  logic          tx_wr,
  input  logic [DW-1:0] tx_data,
  output logic          sel_act,
  output logic          xfer_done,
  output logic [DW-1:0] rx_char,
  output logic          dout,
  output logic [CW-1:0] bit_cnt
);
  localparam int HALF = DW / 2;
  localparam logic [CW-1:0] LAST_WIDE   = CW'(DW - 1);
  localparam logic [CW-1:0] LAST_NARROW = CW'(HALF - 1);

  logic          sclk_q, sel_q;
  logic [DW-1:0] sr, sr_n;
  logic [CW-1:0] cnt_n;
  logic          dout_n;
  logic          sel_prev, sel_rise, lead, trail, samp, drive;
  logic [CW-1:0] last_idx;
  logic [DW-1:0] shifted;

  always_comb begin
    sel_act  = cfg.sel_pol ? sel_s : ~sel_s;
    sel_prev = cfg.sel_pol ? sel_q : ~sel_q;
    sel_rise = sel_act & ~sel_prev;
    lead     = sel_act & (sclk_q == cfg.cpol) & (sclk_s != cfg.cpol);
    trail    = sel_act & (sclk_q != cfg.cpol) & (sclk_s == cfg.cpol);
    samp     = cfg.cpha ? trail : lead;
    drive    = cfg.cpha ? lead  : trail;
    last_idx = cfg.wide ? LAST_WIDE : LAST_NARROW;
    shifted  = {sr[DW-2:0], mosi_s};
    xfer_done = samp && (bit_cnt == last_idx);
    rx_char  = cfg.wide ? shifted : {{(DW-HALF){1'b0}}, shifted[HALF-1:0]};
  end

  // next-state
  always_comb begin
    sr_n   = sr;
    cnt_n  = bit_cnt;
    dout_n = dout;
    if (!sel_act) begin
      cnt_n = '0;
    end else if (samp) begin
      sr_n  = shifted;
      cnt_n = xfer_done ? '0 : bit_cnt + 1'b1;
    end
    if (tx_wr && (bit_cnt == '0) && !samp) sr_n = tx_data;
    if (sel_rise || drive) dout_n = sr[last_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      sel_q   <= 1'b0;
      sr      <= '0;
      bit_cnt <= '0;
      dout    <= 1'b0;
    end else begin
      sclk_q  <= sclk_s;
      sel_q   <= sel_s;
      sr      <= sr_n;
      bit_cnt <= cnt_n;
      dout    <= dout_n;
    end
  end
endmodule

// File: rtl/spi_tgt_host.sv
module spi_tgt_host #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          xfer_done,
  input  logic [DW-1:0] rx_char,
  input  logic          done_clr,
  input  logic          irq_en,
  output logic [DW-1:0] rx_data,
  output logic          done_flag,
  output logic          irq
);
  logic flag_n;

  always_comb begin
    flag_n = done_flag;
    if (done_clr)  flag_n = 1'b0;
    if (xfer_done) flag_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data   <= '0;
      done_flag <= 1'b0;
    end else begin
      if (xfer_done) rx_data <= rx_char;
      done_flag <= flag_n;
    end
  end

  assign irq = done_flag & irq_en;
endmodule

// File: rtl/spi_target_port.sv
module spi_target_port
  import spi_tgt_pkg::*;
#(
  parameter int DW = 16,
  parameter int SYNC_STAGES = 2,
  localparam int CW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_sel_pol,
  input  logic          cfg_cpol,
  input  logic          cfg_cpha,
  input  logic          cfg_wide,
  input  logic          cfg_irq_en,
  input  logic          tx_wr,
  input  logic [DW-1:0] tx_data,
  output logic [DW-1:0] rx_data,
  output logic          done_flag,
  input  logic          done_clr,
  output logic          irq,
  input  logic          sclk_in,
  input  logic          sel_in,
  input  logic          mosi_in,
  output logic          miso_out,
  output logic          miso_oe
);
  logic [1:0]    rst_pipe;
  logic          rst_i_n;
  spi_cfg_t      cfg;
  logic [2:0]    pins_s;
  logic          sel_act, xfer_done, dout;
  logic [DW-1:0] rx_char;
  logic [CW-1:0] bit_cnt;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i_n = rst_pipe[1];

  assign cfg = '{sel_pol: cfg_sel_pol, cpol: cfg_cpol, cpha: cfg_cpha, wide: cfg_wide};

  spi_tgt_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_i_n),
    .d({sclk_in, sel_in, mosi_in}), .q(pins_s)
  );

  spi_tgt_engine #(.DW(DW)) u_engine (
    .clk(clk), .rst_n(rst_i_n), .cfg(cfg),
    .sclk_s(pins_s[2]), .sel_s(pins_s[1]), .mosi_s(pins_s[0]),
    .tx_wr(tx_wr), .tx_data(tx_data),
    .sel_act(sel_act), .xfer_done(xfer_done), .rx_char(rx_char),
    .dout(dout), .bit_cnt(bit_cnt)
  );

  spi_tgt_host #(.DW(DW)) u_host (
    .clk(clk), .rst_n(rst_i_n), .xfer_done(xfer_done), .rx_char(rx_char),
    .done_clr(done_clr), .irq_en(cfg_irq_en),
    .rx_data(rx_data), .done_flag(done_flag), .irq(irq)
  );

  assign miso_out = dout;
  assign miso_oe  = sel_act;
endmodule

// File: rtl/spi_tgt_checker.sv
module spi_tgt_checker #(
  parameter int DW = 16,
  localparam int CW = $clog2(DW)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_irq_en,
  input logic          cfg_wide,
  input logic          done_clr,
  input logic [DW-1:0] rx_data,
  input logic          done_flag,
  input logic          irq,
  input logic          miso_oe,
  input logic          sel_act,
  input logic          xfer_done,
  input logic [CW-1:0] bit_cnt
);
  p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> done_flag);

  p_flag_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_clr && !xfer_done) |=> !done_flag);

  p_rbuf_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_done |=> $stable(rx_data));

  p_irq_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(xfer_done) || $past(!cfg_irq_en)));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_act |-> (!miso_oe && !xfer_done));

  p_abort_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_act |=> (bit_cnt == '0));

  p_len_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wide && $stable(cfg_wide)) |-> (bit_cnt < CW'(DW/2)));
endmodule

bind spi_target_port spi_tgt_checker #(.DW(DW)) u_chk (.*);

// File: tb/tb_spi_target_port.sv
module tb_spi_target_port;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_sel_pol, cfg_cpol, cfg_cpha, cfg_wide, cfg_irq_en;
  logic        tx_wr, done_clr;
  logic [15:0] tx_data, rx_data;
  logic        done_flag, irq;
  logic        sclk_in, sel_in, mosi_in, miso_out, miso_oe;

  int n_chk = 0, n_fail = 0, half = 6;
  bit finished = 0;

  always #5 clk = ~clk;

  spi_target_port dut (.*);

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mode(input bit pol, input bit cpol, input bit cpha, input bit wide);
    sclk_in = cpol;
    wait_n(5);
    cfg_sel_pol = pol; cfg_cpol = cpol; cfg_cpha = cpha; cfg_wide = wide;
    sel_in = ~pol;
    wait_n(5);
  endtask

  task automatic load_tx(input logic [15:0] v);
    @(negedge clk); tx_data = v; tx_wr = 1'b1;
    @(negedge clk); tx_wr = 1'b0;
  endtask

  task automatic clear_flag;
    @(negedge clk); done_clr = 1'b1;
    @(negedge clk); done_clr = 1'b0;
  endtask

  // master side; nbits < char length gives an aborted transfer
  task automatic xfer(input logic [15:0] mo, input logic [15:0] exp_mi,
                      input int nbits, input bit chk_mi, input string req);
    sel_in = cfg_sel_pol;
    mosi_in = mo[nbits-1];
    wait_n(half);
    if (chk_mi) check("R8 oe while selected", 16'(miso_oe), 16'd1);
    for (int i = nbits - 1; i >= 0; i--) begin
      if (!cfg_cpha) begin
        mosi_in = mo[i];
        if (i != nbits - 1) wait_n(half);
        if (chk_mi) check(req, 16'(miso_out), 16'(exp_mi[i]));
        sclk_in = ~cfg_cpol;
        wait_n(half);
        sclk_in = cfg_cpol;
      end else begin
        sclk_in = ~cfg_cpol;
        mosi_in = mo[i];
        wait_n(half);
        if (chk_mi) check(req, 16'(miso_out), 16'(exp_mi[i]));
        sclk_in = cfg_cpol;
        wait_n(half);
      end
    end
    wait_n(half + 4);
    sel_in = ~cfg_sel_pol;
    wait_n(6);
  endtask

  task automatic t_reset;
    check("R6 reset rx_data", rx_data, 16'h0);
    check("R6 reset flag", 16'(done_flag), 16'd0);
    check("R7 reset irq", 16'(irq), 16'd0);
    check("R8 reset oe", 16'(miso_oe), 16'd0);
  endtask

  task automatic t_modes;
    for (int m = 0; m < 4; m++) begin
      logic [15:0] tv = 16'h00A5 ^ 16'(m * 17);
      logic [15:0] mv = 16'h003C ^ 16'(m * 41);
      set_mode(m[0], m[1], m[0] ^ m[1], 1'b0);
      load_tx(tv);
      xfer(mv, tv, 8, 1'b1, "R4 R3 R1 miso bit 8-bit");
      check("R3 rx char", rx_data, {8'h00, mv[7:0]});
      check("R5 upper byte zero", 16'(rx_data[15:8]), 16'h0);
      check("R6 flag set", 16'(done_flag), 16'd1);
      check("R8 oe released", 16'(miso_oe), 16'd0);
      clear_flag();
      check("R6 flag cleared", 16'(done_flag), 16'd0);
    end
  endtask

  task automatic t_wide;
    for (int m = 0; m < 4; m++) begin
      set_mode(m[1], m[0], m[1], 1'b1);
      load_tx(16'hC3A9 + 16'(m));
      xfer(16'h96E1 - 16'(m), 16'hC3A9 + 16'(m), 16, 1'b1, "R5 R4 miso bit 16-bit");
      check("R5 rx 16-bit", rx_data, 16'h96E1 - 16'(m));
      check("R6 flag 16-bit", 16'(done_flag), 16'd1);
      clear_flag();
    end
  endtask

  task automatic t_stale;
    set_mode(1'b0, 1'b0, 1'b0, 1'b0);
    load_tx(16'h0011);
    xfer(16'h005E, 16'h0011, 8, 1'b1, "R10 loaded char");
    xfer(16'h00B2, 16'h005E, 8, 1'b1, "R10 stale char resent");
    check("R10 rx after stale", rx_data, 16'h00B2);
    clear_flag();
  endtask

  task automatic t_ignore;
    set_mode(1'b1, 1'b0, 1'b1, 1'b0);
    load_tx(16'h0077);
    for (int k = 0; k < 10; k++) begin
      sclk_in = ~sclk_in; mosi_in = k[0]; wait_n(half);
    end
    sclk_in = 1'b0; wait_n(6);
    check("R8 no flag while idle", 16'(done_flag), 16'd0);
    check("R8 oe idle", 16'(miso_oe), 16'd0);
    check("R1 inactive level low", rx_data, 16'h00B2);
    xfer(16'h00E4, 16'h0077, 8, 1'b1, "R8 clean after idle clocks");
    check("R8 rx after idle clocks", rx_data, 16'h00E4);
    clear_flag();
  endtask

  task automatic t_abort;
    set_mode(1'b0, 1'b1, 1'b0, 1'b0);
    load_tx(16'h005A);
    xfer(16'h0005, 16'h0002, 3, 1'b1, "R9 partial miso");
    check("R9 no flag on abort", 16'(done_flag), 16'd0);
    check("R9 rx unchanged", rx_data, 16'h00E4);
    load_tx(16'h00C6);
    xfer(16'h0019, 16'h00C6, 8, 1'b1, "R9 restart from bit 0");
    check("R9 rx after abort", rx_data, 16'h0019);
    check("R9 flag after abort", 16'(done_flag), 16'd1);
    clear_flag();
  endtask

  task automatic t_irq;
    set_mode(1'b0, 1'b0, 1'b0, 1'b0);
    cfg_irq_en = 1'b0;
    xfer(16'h0033, 16'h0019, 8, 1'b0, "R7");
    check("R7 irq masked", 16'(irq), 16'd0);
    cfg_irq_en = 1'b1; wait_n(1);
    check("R7 irq enabled", 16'(irq), 16'd1);
    clear_flag();
    check("R7 irq after clear", 16'(irq), 16'd0);
  endtask

  task automatic t_fast;
    half = 2;
    set_mode(1'b1, 1'b1, 1'b1, 1'b1);
    xfer(16'h5AC3, 16'h0, 16, 1'b0, "R2");
    check("R2 rx at clk/4", rx_data, 16'h5AC3);
    half = 6;
    clear_flag();
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    rst_n = 1'b0;
    cfg_sel_pol = 0; cfg_cpol = 0; cfg_cpha = 0; cfg_wide = 0; cfg_irq_en = 0;
    tx_wr = 0; tx_data = '0; done_clr = 0;
    sclk_in = 0; sel_in = 1; mosi_in = 0;
    wait_n(4);
    rst_n = 1'b1;
    wait_n(4);
    t_reset();
    t_modes();
    t_wide();
    t_stale();
    t_ignore();
    t_abort();
    t_irq();
    t_fast();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule